// File: doc/BRIEF.md
# PS/2 Host Controller Register Core

This block is the processor-facing register core of a two-port keyboard and mouse controller. The processor reaches it through two addresses. The data address reads the one-byte output buffer and writes the one-byte input buffer. The command address accepts controller commands on writes, and its status byte can be read at any time. Commands are carried out inside the core. Some commands return a response byte, some wait for a parameter written to the data address, one selects the second device port for the next data byte, and one requests a processor reset pulse.

The output buffer is shared by controller responses and by bytes received from the two device ports. Device bytes arrive over byte-valid/ready channels. A port is held off while the buffer is occupied or while the port is disabled in the configuration byte. Each port has its own interrupt line. The line is active while the buffered byte came from that port and its enable bit is set. Outgoing data bytes leave over one byte-valid/ready channel per port. Serial line timing and scan code translation belong to other blocks.

Top module: `kbc_host_regs`

## Requirements
- R1: After reset the status byte is 0x00, the configuration byte equals the CFG_INIT parameter (default 0x00), no transmit channel is valid, both interrupt lines are low and the reset output is low.
- R2: The status byte packs the output-buffer-full flag in bit 0 and the input-buffer-full flag in bit 1. A data-address read returns the output buffer, and bit 0 is clear in the cycle after the read unless a response is loaded in that same cycle.
- R3: Command 0x20 loads the configuration byte into the output buffer. Command 0x60 makes the next data-address write replace the configuration byte; that byte does not set status bit 1 and is not sent to any port.
- R4: Command 0xAA loads 0x55 into the output buffer.
- R5: Command 0xAB loads the port 1 test result and command 0xA9 loads the port 2 test result. The result is 0x00 when the port's link-ok input is high and 0x01 when it is low.
- R6: A data-address write without a port-2 prefix sets status bit 1 and drives the byte on the port 1 transmit channel. The byte stays valid and stable until ready is seen, and bit 1 clears after that handshake.
- R7: After command 0xD4, exactly one following data byte goes to the port 2 transmit channel. The two transmit channels are never valid together.
- R8: A data-address write while status bit 1 is set is dropped. The pending outgoing byte is unchanged.
- R9: A received byte is accepted only while the output buffer is empty, no response is being loaded and the port is enabled. Configuration bit 4 disables port 1 and bit 5 disables port 2. Port 1 wins when both ports offer a byte. Status bit 5 is set while the buffered byte came from port 2.
- R10: The port 1 interrupt is high while the output buffer holds a port 1 byte and configuration bit 0 is set. The port 2 interrupt is high while it holds a port 2 byte and configuration bit 1 is set.
- R11: A command response loads the output buffer even when it is full, replacing any device byte. The buffered byte is then marked as a controller byte, so status bit 5 and both interrupts are low.
- R12: Command 0xFE drives the reset output high from the next cycle for RST_CYCLES cycles (default 4). A further 0xFE while the pulse is active is ignored.
- R13: A command code not listed above produces no response and cancels any pending parameter or port-2 prefix. A following data byte then goes to port 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_data_wr | input | 1 | Write strobe, data address |
| host_data_rd | input | 1 | Read strobe, data address |
| host_cmd_wr | input | 1 | Write strobe, command address |
| host_wdata | input | 8 | Write data for either address |
| host_rdata | output | 8 | Output buffer contents |
| host_status | output | 8 | Status byte |
| p1_link_ok | input | 1 | Port 1 line check result used by the port test |
| p2_link_ok | input | 1 | Port 2 line check result used by the port test |
| p1_tx_valid | output | 1 | Byte for port 1 is valid |
| p1_tx_ready | input | 1 | Port 1 takes the byte |
| p1_tx_data | output | 8 | Byte for port 1 |
| p2_tx_valid | output | 1 | Byte for port 2 is valid |
| p2_tx_ready | input | 1 | Port 2 takes the byte |
| p2_tx_data | output | 8 | Byte for port 2 |
| p1_rx_valid | input | 1 | Port 1 offers a received byte |
| p1_rx_ready | output | 1 | Core accepts the port 1 byte |
| p1_rx_data | input | 8 | Received byte from port 1 |
| p2_rx_valid | input | 1 | Port 2 offers a received byte |
| p2_rx_ready | output | 1 | Core accepts the port 2 byte |
| p2_rx_data | input | 8 | Received byte from port 2 |
| irq_p1 | output | 1 | Port 1 interrupt |
| irq_p2 | output | 1 | Port 2 interrupt |
| cpu_reset_out | output | 1 | Processor reset pulse |

## Verification
On every cycle the assertions check the following:
- a full output buffer holds both receive channels off and keeps its byte;
- a response always replaces the buffer;
- a read empties the buffer;
- a pending outgoing byte stays stable and is never offered to both ports;
- a configuration parameter never reaches a transmit channel;
- a reset request starts the pulse and is not restarted while it runs.

Only the bench scenarios show the command codes and their response values, the port-2 prefix lasting for one byte, cancellation by an unknown command, the exact pulse length, port 1 priority, and the interrupt masking. The behavioural model compares all of these on every clock.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam int DW = 8;

  typedef enum logic [1:0] {SRC_CTRL = 2'd0, SRC_P1 = 2'd1, SRC_P2 = 2'd2} ob_src_e;

  localparam logic [DW-1:0] OP_RD_CFG    = 8'h20;
  localparam logic [DW-1:0] OP_WR_CFG    = 8'h60;
  localparam logic [DW-1:0] OP_SELFTEST  = 8'hAA;
  localparam logic [DW-1:0] OP_TEST_P1   = 8'hAB;
  localparam logic [DW-1:0] OP_TEST_P2   = 8'hA9;
  localparam logic [DW-1:0] OP_TO_P2     = 8'hD4;
  localparam logic [DW-1:0] OP_PULSE_RST = 8'hFE;
  localparam logic [DW-1:0] SELFTEST_OK  = 8'h55;

  localparam int CFG_IRQ1 = 0;
  localparam int CFG_IRQ2 = 1;
  localparam int CFG_OFF1 = 4;
  localparam int CFG_OFF2 = 5;

  function automatic logic [DW-1:0] port_test_code(input logic link_ok);
    return link_ok ? 8'h00 : 8'h01;
  endfunction

  function automatic logic [DW-1:0] status_pack(input logic obf, input logic ibf,
                                                input logic from_p2);
    logic [DW-1:0] s;
    s    = '0;
    s[0] = obf;
    s[1] = ibf;
    s[5] = from_p2;
    return s;
  endfunction
endpackage

// File: rtl/kbc_cmd_ctrl.sv
module kbc_cmd_ctrl
  import kbc_pkg::*;
#(
  parameter logic [7:0] CFG_INIT = 8'h00
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic          data_wr,
  input  logic [DW-1:0] wdata,
  input  logic          fwd_taken,
  input  logic          p1_link_ok,
  input  logic          p2_link_ok,
  output logic          resp_vld,
  output logic [DW-1:0] resp_byte,
  output logic          param_take,
  output logic          fwd_req,
  output logic          fwd_to_p2,
  output logic          rst_req,
  output logic          p1_irq_en,
  output logic          p2_irq_en,
  output logic          p1_off,
  output logic          p2_off
);
  logic [DW-1:0] cfg;
  logic          pend_cfg;
  logic          pend_p2;

  assign param_take = data_wr & ~cmd_wr & pend_cfg;
  assign fwd_req    = data_wr & ~cmd_wr & ~pend_cfg;
  assign fwd_to_p2  = pend_p2;
  assign p1_irq_en  = cfg[CFG_IRQ1];
  assign p2_irq_en  = cfg[CFG_IRQ2];
  assign p1_off     = cfg[CFG_OFF1];
  assign p2_off     = cfg[CFG_OFF2];

  always_comb begin
    resp_vld  = 1'b0;
    resp_byte = '0;
    rst_req   = 1'b0;
    if (cmd_wr) begin
      case (wdata)
        OP_RD_CFG:    begin resp_vld = 1'b1; resp_byte = cfg; end
        OP_SELFTEST:  begin resp_vld = 1'b1; resp_byte = SELFTEST_OK; end
        OP_TEST_P1:   begin resp_vld = 1'b1; resp_byte = port_test_code(p1_link_ok); end
        OP_TEST_P2:   begin resp_vld = 1'b1; resp_byte = port_test_code(p2_link_ok); end
        OP_PULSE_RST: rst_req = 1'b1;
        default:      ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg      <= CFG_INIT;
      pend_cfg <= 1'b0;
      pend_p2  <= 1'b0;
    end else if (cmd_wr) begin
      pend_cfg <= (wdata == OP_WR_CFG);
      pend_p2  <= (wdata == OP_TO_P2);
    end else begin
      if (param_take) begin
        cfg      <= wdata;
        pend_cfg <= 1'b0;
      end
      if (fwd_taken) pend_p2 <= 1'b0;
    end
  end

  AST_CFG_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    param_take |=> (cfg == $past(wdata)) && !pend_cfg); // R3
  AST_PREFIX_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_taken && !cmd_wr |=> !fwd_to_p2); // R7
endmodule

// File: rtl/kbc_inbuf.sv
module kbc_inbuf
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd_req,
  input  logic          fwd_to_p2,
  input  logic [DW-1:0] wdata,
  output logic          fwd_taken,
  output logic          ibf,
  output logic          p1_tx_valid,
  input  logic          p1_tx_ready,
  output logic [DW-1:0] p1_tx_data,
  output logic          p2_tx_valid,
  input  logic          p2_tx_ready,
  output logic [DW-1:0] p2_tx_data
);
  logic [DW-1:0] ibuf;
  logic          dest_p2;
  logic          tx_done;

  assign fwd_taken   = fwd_req & ~ibf;
  assign p1_tx_valid = ibf & ~dest_p2;
  assign p2_tx_valid = ibf & dest_p2;
  assign p1_tx_data  = ibuf;
  assign p2_tx_data  = ibuf;
  assign tx_done     = (p1_tx_valid & p1_tx_ready) | (p2_tx_valid & p2_tx_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ibuf    <= '0;
      ibf     <= 1'b0;
      dest_p2 <= 1'b0;
    end else if (fwd_taken) begin
      ibuf    <= wdata;
      ibf     <= 1'b1;
      dest_p2 <= fwd_to_p2;
    end else if (tx_done) begin
      ibf     <= 1'b0;
    end
  end

  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({p1_tx_valid, p2_tx_valid})); // R7
  AST_TX1_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    p1_tx_valid && !p1_tx_ready |=> p1_tx_valid && $stable(p1_tx_data)); // R6
  AST_TX2_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    p2_tx_valid && !p2_tx_ready |=> p2_tx_valid && $stable(p2_tx_data)); // R7
  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ibf && fwd_req && !tx_done |=> ibf && $stable(p1_tx_data)); // R8
endmodule

// File: rtl/kbc_outbuf.sv
module kbc_outbuf
  import kbc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          resp_vld,
  input  logic [DW-1:0] resp_byte,
  input  logic          data_rd,
  input  logic          p1_irq_en,
  input  logic          p2_irq_en,
  input  logic          p1_off,
  input  logic          p2_off,
  input  logic          p1_rx_valid,
  output logic          p1_rx_ready,
  input  logic [DW-1:0] p1_rx_data,
  input  logic          p2_rx_valid,
  output logic          p2_rx_ready,
  input  logic [DW-1:0] p2_rx_data,
  output logic [DW-1:0] obuf,
  output logic          obf,
  output logic          from_p2,
  output logic          irq_p1,
  output logic          irq_p2
);
  ob_src_e src;
  logic    take_p1;
  logic    take_p2;
  logic    room;

  assign room        = ~obf & ~resp_vld;
  assign p1_rx_ready = room & ~p1_off;
  assign p2_rx_ready = room & ~p2_off & ~(p1_rx_valid & ~p1_off);
  assign take_p1     = p1_rx_valid & p1_rx_ready;
  assign take_p2     = p2_rx_valid & p2_rx_ready;

  assign from_p2 = obf & (src == SRC_P2);
  assign irq_p1  = obf & (src == SRC_P1) & p1_irq_en;
  assign irq_p2  = from_p2 & p2_irq_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      obuf <= '0;
      obf  <= 1'b0;
      src  <= SRC_CTRL;
    end else if (resp_vld) begin
      obuf <= resp_byte;
      obf  <= 1'b1;
      src  <= SRC_CTRL;
    end else if (take_p1) begin
      obuf <= p1_rx_data;
      obf  <= 1'b1;
      src  <= SRC_P1;
    end else if (take_p2) begin
      obuf <= p2_rx_data;
      obf  <= 1'b1;
      src  <= SRC_P2;
    end else if (data_rd) begin
      obf  <= 1'b0;
    end
  end

  AST_RESP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    resp_vld |=> obf && !from_p2 && (obuf == $past(resp_byte))); // R11
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd && obf && !resp_vld |=> !obf); // R2
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    obf && !resp_vld && !data_rd |=> obf && $stable(obuf)); // R9
  AST_NO_RX_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    obf |-> !p1_rx_ready && !p2_rx_ready); // R9
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_p1 && irq_p2)); // R10
endmodule

// File: rtl/kbc_rst_pulse.sv
module kbc_rst_pulse #(
  parameter int RST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt;

  assign pulse = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (trig && !pulse)    cnt <= CW'(RST_CYCLES);
    else if (pulse)             cnt <= cnt - CW'(1);
  end

  AST_RST_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    trig && !pulse |=> pulse); // R12
  AST_RST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> cnt == $past(cnt) - CW'(1)); // R12
endmodule

// File: rtl/kbc_host_regs.sv
module kbc_host_regs
  import kbc_pkg::*;
#(
  parameter logic [7:0] CFG_INIT   = 8'h00,
  parameter int         RST_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_data_wr,
  input  logic       host_data_rd,
  input  logic       host_cmd_wr,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  output logic [7:0] host_status,
  input  logic       p1_link_ok,
  input  logic       p2_link_ok,
  output logic       p1_tx_valid,
  input  logic       p1_tx_ready,
  output logic [7:0] p1_tx_data,
  output logic       p2_tx_valid,
  input  logic       p2_tx_ready,
  output logic [7:0] p2_tx_data,
  input  logic       p1_rx_valid,
  output logic       p1_rx_ready,
  input  logic [7:0] p1_rx_data,
  input  logic       p2_rx_valid,
  output logic       p2_rx_ready,
  input  logic [7:0] p2_rx_data,
  output logic       irq_p1,
  output logic       irq_p2,
  output logic       cpu_reset_out
);
  logic          resp_vld;
  logic [DW-1:0] resp_byte;
  logic          param_take;
  logic          fwd_req;
  logic          fwd_to_p2;
  logic          fwd_taken;
  logic          rst_req;
  logic          p1_irq_en;
  logic          p2_irq_en;
  logic          p1_off;
  logic          p2_off;
  logic          ibf;
  logic          obf;
  logic          from_p2;

  kbc_cmd_ctrl #(.CFG_INIT(CFG_INIT)) u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(host_cmd_wr), .data_wr(host_data_wr),
    .wdata(host_wdata), .fwd_taken(fwd_taken), .p1_link_ok(p1_link_ok),
    .p2_link_ok(p2_link_ok), .resp_vld(resp_vld), .resp_byte(resp_byte),
    .param_take(param_take), .fwd_req(fwd_req), .fwd_to_p2(fwd_to_p2),
    .rst_req(rst_req), .p1_irq_en(p1_irq_en), .p2_irq_en(p2_irq_en),
    .p1_off(p1_off), .p2_off(p2_off)
  );

  kbc_inbuf u_in (
    .clk(clk), .rst_n(rst_n), .fwd_req(fwd_req), .fwd_to_p2(fwd_to_p2),
    .wdata(host_wdata), .fwd_taken(fwd_taken), .ibf(ibf),
    .p1_tx_valid(p1_tx_valid), .p1_tx_ready(p1_tx_ready), .p1_tx_data(p1_tx_data),
    .p2_tx_valid(p2_tx_valid), .p2_tx_ready(p2_tx_ready), .p2_tx_data(p2_tx_data)
  );

  kbc_outbuf u_out (
    .clk(clk), .rst_n(rst_n), .resp_vld(resp_vld), .resp_byte(resp_byte),
    .data_rd(host_data_rd), .p1_irq_en(p1_irq_en), .p2_irq_en(p2_irq_en),
    .p1_off(p1_off), .p2_off(p2_off),
    .p1_rx_valid(p1_rx_valid), .p1_rx_ready(p1_rx_ready), .p1_rx_data(p1_rx_data),
    .p2_rx_valid(p2_rx_valid), .p2_rx_ready(p2_rx_ready), .p2_rx_data(p2_rx_data),
    .obuf(host_rdata), .obf(obf), .from_p2(from_p2), .irq_p1(irq_p1), .irq_p2(irq_p2)
  );

  kbc_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_rst (
    .clk(clk), .rst_n(rst_n), .trig(rst_req), .pulse(cpu_reset_out)
  );

  assign host_status = status_pack(obf, ibf, from_p2);

  AST_PARAM_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    param_take && !ibf |=> !ibf && !p1_tx_valid && !p2_tx_valid); // R3
  AST_CMD_NOT_FORWARDED: assert property (@(posedge clk) disable iff (!rst_n)
    host_cmd_wr && !ibf |=> !ibf); // R13
endmodule

// File: tb/kbc_host_regs_tb.sv
module kbc_host_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_LEN    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dwr = 0, drd = 0, cwr = 0;
  logic [7:0] wdata = 0;
  logic link1 = 1, link2 = 0;
  logic t1r = 0, t2r = 0, r1v = 0, r2v = 0;
  logic [7:0] r1d = 0, r2d = 0;
  logic [7:0] rdata, status, t1d, t2d;
  logic t1v, t2v, r1r, r2r, irq1, irq2, cpurst;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kbc_host_regs #(.CFG_INIT(8'h00), .RST_CYCLES(RST_LEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_data_wr(dwr), .host_data_rd(drd),
    .host_cmd_wr(cwr), .host_wdata(wdata), .host_rdata(rdata), .host_status(status),
    .p1_link_ok(link1), .p2_link_ok(link2),
    .p1_tx_valid(t1v), .p1_tx_ready(t1r), .p1_tx_data(t1d),
    .p2_tx_valid(t2v), .p2_tx_ready(t2r), .p2_tx_data(t2d),
    .p1_rx_valid(r1v), .p1_rx_ready(r1r), .p1_rx_data(r1d),
    .p2_rx_valid(r2v), .p2_rx_ready(r2r), .p2_rx_data(r2d),
    .irq_p1(irq1), .irq_p2(irq2), .cpu_reset_out(cpurst)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit       m_obf, m_ibf, m_dst, m_pc, m_pp;
  int       m_src;      // 0 controller, 1 port 1, 2 port 2
  logic [7:0] m_ob, m_ib, m_cfg;
  int       m_rc;

  function automatic int m_resp();
    if (!cwr) return -1;
    case (wdata)
      8'h20: return int'(m_cfg);
      8'hAA: return 8'h55;
      8'hAB: return link1 ? 0 : 1;
      8'hA9: return link2 ? 0 : 1;
      default: return -1;
    endcase
  endfunction

  function automatic bit m_r1();
    return !m_obf && (m_resp() < 0) && !m_cfg[4];
  endfunction

  function automatic bit m_r2();
    return !m_obf && (m_resp() < 0) && !m_cfg[5] && !(r1v && !m_cfg[4]);
  endfunction

  always @(posedge clk) begin : model
    int rsp;
    bit a1, a2, old_ibf, hs, trig;
    if (!rst_n) begin
      m_obf = 0; m_ibf = 0; m_dst = 0; m_pc = 0; m_pp = 0; m_src = 0;
      m_ob = 0; m_ib = 0; m_cfg = 8'h00; m_rc = 0;
    end else begin
      rsp = m_resp();
      a1 = m_r1() && r1v;
      a2 = m_r2() && r2v;
      old_ibf = m_ibf;
      hs = m_ibf && (m_dst ? t2r : t1r);
      trig = 0;
      if (rsp >= 0) begin m_obf = 1; m_ob = rsp[7:0]; m_src = 0; end
      else if (a1) begin m_obf = 1; m_ob = r1d; m_src = 1; end
      else if (a2) begin m_obf = 1; m_ob = r2d; m_src = 2; end
      else if (drd) m_obf = 0;
      if (hs) m_ibf = 0;
      if (cwr) begin
        m_pc = (wdata == 8'h60);
        m_pp = (wdata == 8'hD4);
        trig = (wdata == 8'hFE) && (m_rc == 0);
      end else if (dwr) begin
        if (m_pc) begin m_cfg = wdata; m_pc = 0; end
        else if (!old_ibf) begin m_ibf = 1; m_ib = wdata; m_dst = m_pp; m_pp = 0; end
      end
      if (trig) m_rc = RST_LEN;
      else if (m_rc > 0) m_rc--;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2 status", status, {2'b00, m_obf && m_src == 2, 3'b000, m_ibf, m_obf});
      chk("R2 rdata", rdata, m_ob);
      chk("R6 p1 tx valid", t1v, m_ibf && !m_dst);
      chk("R7 p2 tx valid", t2v, m_ibf && m_dst);
      if (m_ibf) chk("R6 tx data", m_dst ? t2d : t1d, m_ib);
      chk("R9 p1 rx ready", r1r, m_r1());
      chk("R9 p2 rx ready", r2r, m_r2());
      chk("R10 irq p1", irq1, m_obf && m_src == 1 && m_cfg[0]);
      chk("R10 irq p2", irq2, m_obf && m_src == 2 && m_cfg[1]);
      chk("R12 reset out", cpurst, m_rc > 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic cmd(input logic [7:0] c);
    cwr = 1; wdata = c; tick(); cwr = 0;
  endtask

  task automatic dwrite(input logic [7:0] d);
    dwr = 1; wdata = d; tick(); dwr = 0;
  endtask

  task automatic dread();
    drd = 1; tick(); drd = 0;
  endtask

  task automatic rx_send(input bit p2, input logic [7:0] d);
    if (p2) begin r2v = 1; r2d = d; end else begin r1v = 1; r1d = d; end
    for (int i = 0; i < 40; i++) begin
      #1;
      if (p2 ? r2r : r1r) begin
        tick();
        if (p2) r2v = 0; else r1v = 0;
        return;
      end
      tick();
    end
    chk("R9 rx accept timeout", 0, 1);
    r1v = 0; r2v = 0;
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int n;
    repeat (3) tick();
    rst_n = 1;
    tick();
    // R1 reset state
    chk("R1 status", status, 8'h00);
    chk("R1 tx idle", {t1v, t2v}, 0);
    chk("R1 irq/reset", {irq1, irq2, cpurst}, 0);
    cmd(8'h20);
    chk("R1 config init", rdata, 8'h00);
    dread();
    chk("R2 read clears bit0", status, 8'h00);

    // R3 configuration write and read back
    cmd(8'h60);
    dwrite(8'h03);
    chk("R3 param not buffered", status, 8'h00);
    chk("R3 param not sent", {t1v, t2v}, 0);
    cmd(8'h20);
    chk("R3 config read", rdata, 8'h03);
    chk("R3 status full", status, 8'h01);
    dread();

    // R4 self test
    cmd(8'hAA);
    chk("R4 self test", rdata, 8'h55);
    dread();

    // R5 port tests
    link1 = 1; link2 = 0;
    cmd(8'hAB);
    chk("R5 port1 pass", rdata, 8'h00);
    dread();
    cmd(8'hA9);
    chk("R5 port2 fail", rdata, 8'h01);
    dread();

    // R6 / R8 forward to port 1, drop second write
    dwrite(8'h11);
    chk("R6 status bit1", status, 8'h02);
    chk("R6 p1 valid", t1v, 1);
    chk("R6 p1 data", t1d, 8'h11);
    dwrite(8'h99);
    tick();
    chk("R8 dropped write", t1d, 8'h11);
    t1r = 1; tick(); t1r = 0;
    chk("R6 handshake clears", status, 8'h00);

    // R7 port-2 prefix for one byte
    cmd(8'hD4);
    dwrite(8'h22);
    chk("R7 p2 valid", {t1v, t2v}, 2'b01);
    chk("R7 p2 data", t2d, 8'h22);
    t2r = 1; tick(); t2r = 0;
    dwrite(8'h33);
    chk("R7 prefix used once", {t1v, t2v}, 2'b10);
    t1r = 1; tick(); t1r = 0;

    // R9 / R10 receive paths
    rx_send(0, 8'h5A);
    chk("R9 p1 byte", rdata, 8'h5A);
    chk("R10 irq p1", {irq1, irq2}, 2'b10);
    r2v = 1; r2d = 8'h77;
    tick(); tick();
    chk("R9 hold off while full", r2r, 0);
    chk("R9 byte kept", rdata, 8'h5A);
    dread();
    tick();
    r2v = 0;
    chk("R9 p2 byte", rdata, 8'h77);
    chk("R9 status bit5", status, 8'h21);
    chk("R10 irq p2", {irq1, irq2}, 2'b01);
    dread();
    r1v = 1; r1d = 8'hA1; r2v = 1; r2d = 8'hB2;
    #1;
    chk("R9 priority ready", {r1r, r2r}, 2'b10);
    tick();
    r1v = 0;
    chk("R9 priority byte", rdata, 8'hA1);
    dread();
    tick();
    r2v = 0;
    chk("R9 second byte", rdata, 8'hB2);
    dread();

    // R9 disabled port 1
    cmd(8'h60); dwrite(8'h13);
    r1v = 1; r1d = 8'hC3;
    #1;
    chk("R9 disabled not ready", r1r, 0);
    tick(); tick();
    chk("R9 disabled ignored", status, 8'h00);
    r1v = 0;

    // R10 masked interrupt
    cmd(8'h60); dwrite(8'h00);
    rx_send(0, 8'h44);
    chk("R10 masked irq", {irq1, irq2}, 2'b00);

    // R11 response replaces a device byte
    cmd(8'hAA);
    chk("R11 overwrite", rdata, 8'h55);
    chk("R11 source ctrl", status, 8'h01);
    dread();
    cmd(8'h60); dwrite(8'h03);
    rx_send(1, 8'h66);
    cmd(8'hAB);
    chk("R11 irq cleared", {irq1, irq2, status[5]}, 0);
    dread();

    // R12 reset pulse length, retrigger ignored
    cmd(8'hFE);
    n = cpurst ? 1 : 0;
    cmd(8'hFE);
    if (cpurst) n++;
    for (int i = 0; i < 20 && cpurst; i++) begin
      tick();
      if (cpurst) n++;
    end
    chk("R12 pulse length", n, RST_LEN);

    // R13 unknown command cancels pending parameter
    cmd(8'h60);
    cmd(8'h12);
    chk("R13 no response", status, 8'h00);
    dwrite(8'h5C);
    chk("R13 byte to port1", {t1v, t2v}, 2'b10);
    chk("R13 byte value", t1d, 8'h5C);
    t1r = 1; tick(); t1r = 0;
    cmd(8'h20);
    chk("R13 config untouched", rdata, 8'h03);
    dread();
    tick(); tick();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule